// File: doc/BRIEF.md
# Per-Bank Open-Row Tracker

This block remembers, for every tracked bank of each SDRAM chip-select, whether a row is open and which row it is. A command sequencer asks it about a pending request by giving the chip-select, bank and row. One cycle later the block answers with one of three classes. A row hit needs only a column command. A row miss needs a precharge and then an activate. A closed bank needs only an activate. Because the class is known early, the sequencer can issue precharge and activate commands behind other traffic.

The sequencer reports the commands it issues back to the block. An activate opens a bank on a row. A precharge closes one bank. A precharge-all closes every bank of one chip-select. Only the first four banks of each chip-select are tracked, so at most eight pages are held across the two chip-selects. A bank above that range is always reported as closed. The answer to a lookup already includes any update issued in the same cycle. This block does not issue memory commands and does not enforce memory timing.

Top module: `row_tracker`

## Requirements
- R1: After reset, and after any later reset, every tracked bank of every chip-select is closed, and `res_valid` is 0 until a lookup is made.
- R2: An activate to a tracked bank stores its row and opens the bank. A later lookup of that bank with the same row reports hit (`res_status` = 2'b01).
- R3: A lookup of an open tracked bank with a different row reports miss (`res_status` = 2'b10). A new activate to an open bank replaces the stored row.
- R4: A precharge closes only the addressed bank. A lookup of that bank then reports closed (`res_status` = 2'b00), and every other bank keeps its state.
- R5: A precharge-all closes every tracked bank of its chip-select and leaves the other chip-select unchanged.
- R6: Banks 4 to 7 are not tracked. An activate to one of them has no effect, and a lookup of one of them reports closed (2'b00).
- R7: The chip-selects are independent. The same bank number on the other chip-select keeps its own state and its own row.
- R8: `res_valid` is 1 in exactly the cycle after a cycle with `lk_valid` = 1. The code 2'b11 is never produced.
- R9: An update in the same cycle as a lookup of the same bank is reflected in that lookup's result. If an activate and a precharge (or precharge-all) address the same bank in one cycle, the activate wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_cs | input | 1 | Lookup chip-select |
| lk_bank | input | 3 | Lookup bank |
| lk_row | input | 14 | Lookup row |
| act_valid | input | 1 | Activate event |
| act_cs | input | 1 | Activate chip-select |
| act_bank | input | 3 | Activate bank |
| act_row | input | 14 | Row being opened |
| pre_valid | input | 1 | Single-bank precharge event |
| pre_cs | input | 1 | Precharge chip-select |
| pre_bank | input | 3 | Precharge bank |
| pall_valid | input | 1 | Precharge-all event |
| pall_cs | input | 1 | Precharge-all chip-select |
| res_valid | output | 1 | Lookup result valid |
| res_status | output | 2 | 00 closed, 01 hit, 10 miss |

## Verification
Every lookup result is registered, so it appears on the rising edge after the edge that accepts the lookup. Update events are captured on that same edge. The bench drives each stimulus on a falling edge, releases it on the next falling edge, and compares `res_valid` and `res_status` at that moment, one edge after capture, while the outputs are stable. Stored state is observed only through lookups made in later steps. The bench therefore checks that state persists, that other banks are left alone, and that same-cycle forwarding works, all through the ports.

// File: rtl/row_trk_pkg.sv
package row_trk_pkg;

    typedef enum logic [1:0] {
        PG_CLOSED = 2'b00,
        PG_HIT    = 2'b01,
        PG_MISS   = 2'b10
    } pg_status_e;

endpackage

// File: rtl/bank_slot.sv
// One tracked bank: open flag plus stored row. The next-state value is also
// exported so a lookup in the same cycle sees the post-update state.
module bank_slot #(
    parameter int ROW_W   = 14,
    parameter int CS_W    = 1,
    parameter int BANK_W  = 3,
    parameter int CS_ID   = 0,
    parameter int BANK_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_valid,
    input  logic [CS_W-1:0]   act_cs,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [ROW_W-1:0]  act_row,
    input  logic              pre_valid,
    input  logic [CS_W-1:0]   pre_cs,
    input  logic [BANK_W-1:0] pre_bank,
    input  logic              pall_valid,
    input  logic [CS_W-1:0]   pall_cs,
    output logic              open_nx,
    output logic [ROW_W-1:0]  row_nx
);

    localparam logic [CS_W-1:0]   MY_CS   = CS_W'(CS_ID);
    localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  close_hit;
    logic  open_hit;

    always_comb begin
        slot_d    = slot_q;
        close_hit = (pre_valid && pre_cs == MY_CS && pre_bank == MY_BANK)
                 || (pall_valid && pall_cs == MY_CS);
        open_hit  = act_valid && act_cs == MY_CS && act_bank == MY_BANK;
        if (close_hit) begin
            slot_d.open = 1'b0;
        end
        // activate is applied last so that it wins over a close
        if (open_hit) begin
            slot_d.open = 1'b1;
            slot_d.row  = act_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign open_nx = slot_d.open;
    assign row_nx  = slot_d.row;

endmodule

// File: rtl/row_classify.sv
// Selects the addressed slot from post-update state and registers the class.
module row_classify
    import row_trk_pkg::*;
#(
    parameter int NUM_CS        = 2,
    parameter int TRACKED_BANKS = 4,
    parameter int CS_W          = 1,
    parameter int BANK_W        = 3,
    parameter int ROW_W         = 14,
    localparam int NUM_SLOTS    = NUM_CS * TRACKED_BANKS
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             lk_valid,
    input  logic [CS_W-1:0]                  lk_cs,
    input  logic [BANK_W-1:0]                lk_bank,
    input  logic [ROW_W-1:0]                 lk_row,
    input  logic [NUM_SLOTS-1:0]             open_nx,
    input  logic [NUM_SLOTS-1:0][ROW_W-1:0]  row_nx,
    output logic                             res_valid,
    output logic [1:0]                       res_status
);

    typedef struct packed {
        logic       valid;
        pg_status_e status;
    } res_t;

    res_t             res_d, res_q;
    logic             sel_open;
    logic [ROW_W-1:0] sel_row;

    always_comb begin
        sel_open = 1'b0;
        sel_row  = '0;
        for (int c = 0; c < NUM_CS; c++) begin
            for (int b = 0; b < TRACKED_BANKS; b++) begin
                if (lk_cs == CS_W'(c) && lk_bank == BANK_W'(b)) begin
                    sel_open = open_nx[c*TRACKED_BANKS + b];
                    sel_row  = row_nx[c*TRACKED_BANKS + b];
                end
            end
        end

        res_d.valid  = lk_valid;
        res_d.status = PG_CLOSED;
        if (lk_valid && sel_open) begin
            res_d.status = (sel_row == lk_row) ? PG_HIT : PG_MISS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '{valid: 1'b0, status: PG_CLOSED};
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid  = res_q.valid;
    assign res_status = res_q.status;

endmodule

// File: rtl/row_tracker.sv
module row_tracker #(
    parameter int NUM_CS        = 2,
    parameter int TRACKED_BANKS = 4,
    parameter int BANK_W        = 3,
    parameter int ROW_W         = 14,
    localparam int CS_W         = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int NUM_SLOTS    = NUM_CS * TRACKED_BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [CS_W-1:0]   lk_cs,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    input  logic              act_valid,
    input  logic [CS_W-1:0]   act_cs,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [ROW_W-1:0]  act_row,
    input  logic              pre_valid,
    input  logic [CS_W-1:0]   pre_cs,
    input  logic [BANK_W-1:0] pre_bank,
    input  logic              pall_valid,
    input  logic [CS_W-1:0]   pall_cs,
    output logic              res_valid,
    output logic [1:0]        res_status
);

    logic [NUM_SLOTS-1:0]            open_nx;
    logic [NUM_SLOTS-1:0][ROW_W-1:0] row_nx;

    for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
        for (genvar b = 0; b < TRACKED_BANKS; b++) begin : g_bank
            bank_slot #(
                .ROW_W  (ROW_W),
                .CS_W   (CS_W),
                .BANK_W (BANK_W),
                .CS_ID  (c),
                .BANK_ID(b)
            ) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .act_valid (act_valid),
                .act_cs    (act_cs),
                .act_bank  (act_bank),
                .act_row   (act_row),
                .pre_valid (pre_valid),
                .pre_cs    (pre_cs),
                .pre_bank  (pre_bank),
                .pall_valid(pall_valid),
                .pall_cs   (pall_cs),
                .open_nx   (open_nx[c*TRACKED_BANKS + b]),
                .row_nx    (row_nx[c*TRACKED_BANKS + b])
            );
        end
    end

    row_classify #(
        .NUM_CS       (NUM_CS),
        .TRACKED_BANKS(TRACKED_BANKS),
        .CS_W         (CS_W),
        .BANK_W       (BANK_W),
        .ROW_W        (ROW_W)
    ) u_classify (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_cs     (lk_cs),
        .lk_bank   (lk_bank),
        .lk_row    (lk_row),
        .open_nx   (open_nx),
        .row_nx    (row_nx),
        .res_valid (res_valid),
        .res_status(res_status)
    );

endmodule

// File: rtl/row_tracker_chk.sv
module row_tracker_chk #(
    parameter int TRACKED_BANKS = 4,
    parameter int CS_W          = 1,
    parameter int BANK_W        = 3,
    parameter int ROW_W         = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [CS_W-1:0]   lk_cs,
    input logic [BANK_W-1:0] lk_bank,
    input logic [ROW_W-1:0]  lk_row,
    input logic              act_valid,
    input logic [CS_W-1:0]   act_cs,
    input logic [BANK_W-1:0] act_bank,
    input logic [ROW_W-1:0]  act_row,
    input logic              pre_valid,
    input logic [CS_W-1:0]   pre_cs,
    input logic [BANK_W-1:0] pre_bank,
    input logic              pall_valid,
    input logic [CS_W-1:0]   pall_cs,
    input logic              res_valid,
    input logic [1:0]        res_status
);

    localparam logic [BANK_W-1:0] TB = BANK_W'(TRACKED_BANKS);

    logic act_on_lk;
    assign act_on_lk = act_valid && act_cs == lk_cs && act_bank == lk_bank;

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    p_no_code3_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_status != 2'b11);

    p_act_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && act_on_lk && lk_bank < TB && lk_row == act_row)
        |=> res_status == 2'b01);

    p_act_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && act_on_lk && lk_bank < TB && lk_row != act_row)
        |=> res_status == 2'b10);

    p_pre_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && pre_valid && pre_cs == lk_cs && pre_bank == lk_bank && !act_on_lk)
        |=> res_status == 2'b00);

    p_pall_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && pall_valid && pall_cs == lk_cs && !act_on_lk)
        |=> res_status == 2'b00);

    p_untracked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_bank >= TB) |=> res_status == 2'b00);

endmodule

bind row_tracker row_tracker_chk #(
    .TRACKED_BANKS(TRACKED_BANKS),
    .CS_W         (CS_W),
    .BANK_W       (BANK_W),
    .ROW_W        (ROW_W)
) u_chk (.*);

// File: tb/tb_row_tracker.sv
module tb_row_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, act_valid = 1'b0, pre_valid = 1'b0, pall_valid = 1'b0;
    logic        lk_cs = 1'b0, act_cs = 1'b0, pre_cs = 1'b0, pall_cs = 1'b0;
    logic [2:0]  lk_bank = '0, act_bank = '0, pre_bank = '0;
    logic [13:0] lk_row = '0, act_row = '0;
    logic        res_valid;
    logic [1:0]  res_status;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    row_tracker dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_cs(lk_cs), .lk_bank(lk_bank), .lk_row(lk_row),
        .act_valid(act_valid), .act_cs(act_cs), .act_bank(act_bank), .act_row(act_row),
        .pre_valid(pre_valid), .pre_cs(pre_cs), .pre_bank(pre_bank),
        .pall_valid(pall_valid), .pall_cs(pall_cs),
        .res_valid(res_valid), .res_status(res_status)
    );

    // ops: 0 none, 1 activate, 2 precharge, 3 precharge-all,
    //      4 activate+precharge same bank, 5 activate+precharge-all
    // fields: op[3] cs[1] bank[3] update_row[14] lookup_row[14] expected[2]
    localparam int NV = 16;
    localparam logic [36:0] VEC [NV] = '{
        {3'd0, 1'b0, 3'd0, 14'h0000, 14'h0123, 2'b00},  // R1 closed after reset
        {3'd1, 1'b0, 3'd0, 14'h0123, 14'h0123, 2'b01},  // R2 R9
        {3'd0, 1'b0, 3'd0, 14'h0000, 14'h0124, 2'b10},  // R3
        {3'd1, 1'b0, 3'd1, 14'h3FFF, 14'h3FFF, 2'b01},  // R2
        {3'd0, 1'b1, 3'd0, 14'h0000, 14'h0123, 2'b00},  // R7
        {3'd1, 1'b1, 3'd0, 14'h0555, 14'h0123, 2'b10},  // R7 R9
        {3'd0, 1'b0, 3'd0, 14'h0000, 14'h0123, 2'b01},  // R7 cs0 kept
        {3'd2, 1'b0, 3'd0, 14'h0000, 14'h0123, 2'b00},  // R4 R9
        {3'd0, 1'b0, 3'd1, 14'h0000, 14'h3FFF, 2'b01},  // R4 neighbour kept
        {3'd1, 1'b0, 3'd5, 14'h0100, 14'h0100, 2'b00},  // R6
        {3'd1, 1'b0, 3'd3, 14'h0000, 14'h0001, 2'b10},  // R3
        {3'd3, 1'b0, 3'd1, 14'h0000, 14'h3FFF, 2'b00},  // R5
        {3'd0, 1'b0, 3'd3, 14'h0000, 14'h0000, 2'b00},  // R5
        {3'd0, 1'b1, 3'd0, 14'h0000, 14'h0555, 2'b01},  // R5 other cs kept
        {3'd1, 1'b0, 3'd2, 14'h1000, 14'h1000, 2'b01},  // R2
        {3'd1, 1'b0, 3'd2, 14'h2000, 14'h1000, 2'b10}   // R3 row replaced
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] op, input logic cs, input logic [2:0] bank,
                        input logic [13:0] urow, input logic lk, input logic [13:0] lrow);
        @(negedge clk);
        act_valid  = (op == 3'd1 || op == 3'd4 || op == 3'd5);
        pre_valid  = (op == 3'd2 || op == 3'd4);
        pall_valid = (op == 3'd3 || op == 3'd5);
        act_cs = cs; pre_cs = cs; pall_cs = cs;
        act_bank = bank; pre_bank = bank; act_row = urow;
        lk_valid = lk; lk_cs = cs; lk_bank = bank; lk_row = lrow;
        @(negedge clk);
        act_valid = 1'b0; pre_valid = 1'b0; pall_valid = 1'b0; lk_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {1'b0, res_valid}, 2'b00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][36:34], VEC[i][33], VEC[i][32:30], VEC[i][29:16], 1'b1, VEC[i][15:2]);
            check($sformatf("R8 valid vec %0d", i), {1'b0, res_valid}, 2'b01);
            check($sformatf("vec %0d status", i), res_status, VEC[i][1:0]);
        end

        // R8: no lookup, no result
        step(3'd0, 1'b0, 3'd0, 14'h0, 1'b0, 14'h0);
        check("R8 idle valid", {1'b0, res_valid}, 2'b00);

        // R9: activate beats precharge in the same cycle
        step(3'd4, 1'b1, 3'd3, 14'h0007, 1'b1, 14'h0007);
        check("R9 act over pre", res_status, 2'b01);
        // R9: activate beats precharge-all on its bank
        step(3'd5, 1'b1, 3'd2, 14'h0009, 1'b1, 14'h0009);
        check("R9 act over pall", res_status, 2'b01);
        step(3'd0, 1'b1, 3'd3, 14'h0, 1'b1, 14'h0007);
        check("R9 pall closed other bank", res_status, 2'b00);
        // R6: lookup of untracked bank 7
        step(3'd0, 1'b1, 3'd7, 14'h0, 1'b1, 14'h0000);
        check("R6 bank7 closed", res_status, 2'b00);

        // R1: mid-run reset clears state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        step(3'd0, 1'b1, 3'd2, 14'h0, 1'b1, 14'h0009);
        check("R1 cleared after reset", res_status, 2'b00);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule